// File: doc/BRIEF.md
# Sampled Quadrature Motion Decoder

This block watches the two phase lines of an incremental encoder and turns their movement into a signed displacement. Each line first passes through a short synchronizer. A programmable timer then samples the pair at fixed intervals. Each sample compares the new A/B state with the one taken at the previous sample, giving a step of +1, 0 or -1. When both lines changed between two samples, the direction cannot be known, so the step counts as invalid. Valid steps go into a saturating signed accumulator, and invalid ones go into a small saturating counter.

Samples are grouped into reports of a programmable length. Software reads motion through snapshot tasks: each one copies a running total into a read-out register and zeroes the total in the same cycle, so no step is lost or counted twice. Five sticky event flags, a per-event interrupt enable and a set of event-to-task shortcuts let the block work either by polling or through interrupts. A shortcut can, for example, snapshot the totals at the end of every report without software taking part.

Top module: `quad_motion_decoder`

## Requirements
- R1: After reset the event flags, interrupt enables, `irq`, `running`, `last_sample`, `acc_snap` and `dbl_snap` are all zero.
- R2: While running, the block samples once every (128 << min(sample_code,10)) × TICKS_PER_US clock cycles, so codes 0 to 10 double the interval step by step from 128 µs. Codes above 10 act as 10. No sample is taken while the block is idle.
- R3: The A/B state is mapped to a position as {A,B} 00→0, 01→1, 11→2, 10→3. With d = (new − old) mod 4, d=1 gives step +1, d=3 gives −1, and d=0 gives 0. For d=2 the step is 0 and the sample counts as invalid. `last_sample` holds the latest step as 2-bit two's complement.
- R4: The accumulator is ACC_W bits, signed. It adds every step and clamps at its most positive and most negative values instead of wrapping. A sample that clamps raises the overflow event (flag bit 2).
- R5: Each invalid sample adds one to a 4-bit count, which stops at 15.
- R6: `task_snap_all` copies both totals to `acc_snap` and `dbl_snap` and clears them. `task_snap_acc` does this for the accumulator only, and `task_snap_dbl` for the invalid count only. A total that is not snapshotted keeps its value.
- R7: A report ends after N samples, counted from start. `report_code` 0 gives N=10, codes 1 to 7 give N=40×code, code 8 gives N=1, and any other code gives N=10. The end of a report raises flag bit 1. If the invalid count, including that sample, is then nonzero, flag bit 3 is raised as well.
- R8: There are five flags: bit 0 sample taken, 1 report done, 2 overflow, 3 invalid count ready, 4 stopped. A flag stays set until its `evt_clr` bit is pulsed. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq_en` bits are set by `irq_en_set` and cleared by `irq_en_clr`, using the flag bit order. `irq` is high one cycle after any flag that has its enable bit set.
- R10: `task_start` begins sampling only when `enable` is high. A stop task given while running halts sampling and raises flag bit 4. Dropping `enable` halts sampling without raising flag bit 4.
- R11: `shortcut_en` bits fire a task one cycle after the event: bit 0 report→snapshot both, bit 1 sample→stop, bit 2 report→snapshot accumulator, bit 3 report→stop, bit 4 invalid-ready→snapshot invalid count, bit 5 invalid-ready→stop, bit 6 sample→snapshot both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_a | input | 1 | Encoder phase A (asynchronous) |
| ph_b | input | 1 | Encoder phase B (asynchronous) |
| enable | input | 1 | Global enable |
| sample_code | input | 4 | Sample interval code |
| report_code | input | 4 | Samples-per-report code |
| shortcut_en | input | 7 | Event-to-task shortcut enables |
| task_start | input | 1 | Start pulse |
| task_stop | input | 1 | Stop pulse |
| task_snap_all | input | 1 | Snapshot and clear both totals |
| task_snap_acc | input | 1 | Snapshot and clear accumulator |
| task_snap_dbl | input | 1 | Snapshot and clear invalid count |
| evt_clr | input | 5 | Per-flag clear pulses |
| irq_en_set | input | 5 | Interrupt enable set pulses |
| irq_en_clr | input | 5 | Interrupt enable clear pulses |
| evt_flags | output | 5 | Sticky event flags |
| irq_en | output | 5 | Current interrupt enables |
| irq | output | 1 | Interrupt request |
| running | output | 1 | Sampling active |
| last_sample | output | 2 | Latest step, signed |
| acc_snap | output | ACC_W | Accumulator snapshot |
| dbl_snap | output | 4 | Invalid count snapshot |

## Verification
The bench sweeps all sixteen pairs of old and new phase states. A decoder that mixed up the Gray order would report the wrong direction, and one that missed the two-bit jump would count a reversal or let the invalid counter stand still. With a narrow accumulator, long runs in both directions drive the total into its limits. A wrapping design would show a flipped sign and no overflow flag. Further runs push the invalid count past 15, where a design without clamping would drop back to a small value. The bench also times the gaps between samples and counts samples per report, which catches off-by-one timers and a wrong code table. It checks the shortcuts that snapshot or stop, and it confirms that a snapshot of one total leaves the other intact.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int N_EVT    = 5;
  localparam int N_SHORT  = 7;
  localparam int EV_SAMPLE = 0;
  localparam int EV_REPORT = 1;
  localparam int EV_OVF    = 2;
  localparam int EV_DBL    = 3;
  localparam int EV_STOP   = 4;
  localparam int RPT_W     = 9;
  localparam int DBL_W     = 4;

  // position of an A/B state along the Gray sequence 00,01,11,10
  function automatic logic [1:0] gray_pos(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

  // samples per report for a report code
  function automatic logic [RPT_W-1:0] report_len(input logic [3:0] code);
    logic [RPT_W-1:0] n;
    if (code == 4'd0)      n = RPT_W'(10);
    else if (code <= 4'd7) n = RPT_W'(40) * RPT_W'(code);
    else if (code == 4'd8) n = RPT_W'(1);
    else                   n = RPT_W'(10);
    return n;
  endfunction

  // doubling exponent of the sample interval
  function automatic logic [3:0] period_shift(input logic [3:0] code);
    return (code > 4'd10) ? 4'd10 : code;
  endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/qdec_timer.sv
module qdec_timer
  import qdec_pkg::*;
#(
  parameter int TICKS_PER_US = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [3:0] code,
  output logic       tick
);
  localparam int BASE  = 128 * TICKS_PER_US;
  localparam int MAX_P = BASE << 10;
  localparam int CW    = $clog2(MAX_P + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    limit = (CW'(BASE) << period_shift(code)) - CW'(1);
    tick  = run && (cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

  p_cnt_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/qdec_core.sv
module qdec_core
  import qdec_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [1:0]       ab,
  input  logic             clr_acc,
  input  logic             clr_dbl,
  input  logic [3:0]       rpt_code,
  output logic [ACC_W-1:0] acc_snap,
  output logic [DBL_W-1:0] dbl_snap,
  output logic [1:0]       last_sample,
  output logic             sample_p,
  output logic             report_p,
  output logic             ovf_p,
  output logic             dblrdy_p
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [DBL_W-1:0] DBL_MAX = '1;

  logic [1:0]       prev_ab;
  logic [ACC_W-1:0] acc;
  logic [DBL_W-1:0] dbl;
  logic [RPT_W-1:0] rcnt;

  logic [1:0]       diff, step;
  logic             inv;
  logic [ACC_W-1:0] acc_base, acc_next;
  logic [ACC_W:0]   sum;
  logic             clamp;
  logic [DBL_W-1:0] dbl_base, dbl_next;
  logic             rpt_hit;

  always_comb begin
    diff = gray_pos(ab) - gray_pos(prev_ab);
    inv  = (diff == 2'd2);
    case (diff)
      2'd1:    step = 2'b01;
      2'd3:    step = 2'b11;
      default: step = 2'b00;
    endcase
    acc_base = clr_acc ? '0 : acc;
    sum = {acc_base[ACC_W-1], acc_base} + {{(ACC_W-1){step[1]}}, step};
    clamp = (sum[ACC_W] != sum[ACC_W-1]);
    if (clamp) acc_next = sum[ACC_W] ? ACC_MIN : ACC_MAX;
    else       acc_next = sum[ACC_W-1:0];
    dbl_base = clr_dbl ? '0 : dbl;
    dbl_next = (inv && dbl_base != DBL_MAX) ? dbl_base + DBL_W'(1) : dbl_base;
    rpt_hit  = (rcnt + RPT_W'(1)) >= report_len(rpt_code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ab     <= '0;
      acc         <= '0;
      dbl         <= '0;
      rcnt        <= '0;
      acc_snap    <= '0;
      dbl_snap    <= '0;
      last_sample <= '0;
      sample_p    <= 1'b0;
      report_p    <= 1'b0;
      ovf_p       <= 1'b0;
      dblrdy_p    <= 1'b0;
    end else begin
      sample_p <= 1'b0;
      report_p <= 1'b0;
      ovf_p    <= 1'b0;
      dblrdy_p <= 1'b0;
      if (clr_acc) acc_snap <= acc;
      if (clr_dbl) dbl_snap <= dbl;
      if (restart) begin
        prev_ab <= ab;
        rcnt    <= '0;
      end
      if (tick) begin
        prev_ab     <= ab;
        last_sample <= step;
        acc         <= acc_next;
        dbl         <= dbl_next;
        sample_p    <= 1'b1;
        ovf_p       <= clamp;
        if (rpt_hit) begin
          rcnt     <= '0;
          report_p <= 1'b1;
          dblrdy_p <= (dbl_next != '0);
        end else begin
          rcnt <= rcnt + RPT_W'(1);
        end
      end else begin
        acc <= acc_base;
        dbl <= dbl_base;
      end
    end
  end

  p_acc_clamped_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_p |-> (acc == ACC_MAX || acc == ACC_MIN));
  p_dbl_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (dbl == DBL_MAX && !clr_dbl) |=> (dbl == DBL_MAX));
  p_step_range_r3: assert property (@(posedge clk) disable iff (rst)
    last_sample != 2'b10);
  p_report_with_sample_r7: assert property (@(posedge clk) disable iff (rst)
    report_p |-> sample_p);
endmodule

// File: rtl/quad_motion_decoder.sv
module quad_motion_decoder
  import qdec_pkg::*;
#(
  parameter int TICKS_PER_US = 16,
  parameter int ACC_W        = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ph_a,
  input  logic               ph_b,
  input  logic               enable,
  input  logic [3:0]         sample_code,
  input  logic [3:0]         report_code,
  input  logic [6:0]         shortcut_en,
  input  logic               task_start,
  input  logic               task_stop,
  input  logic               task_snap_all,
  input  logic               task_snap_acc,
  input  logic               task_snap_dbl,
  input  logic [4:0]         evt_clr,
  input  logic [4:0]         irq_en_set,
  input  logic [4:0]         irq_en_clr,
  output logic [4:0]         evt_flags,
  output logic [4:0]         irq_en,
  output logic               irq,
  output logic               running,
  output logic [1:0]         last_sample,
  output logic [ACC_W-1:0]   acc_snap,
  output logic [DBL_W-1:0]   dbl_snap
);
  logic [1:0] ab_s;
  logic       tick;
  logic       sample_p, report_p, ovf_p, dblrdy_p;
  logic       start_go, stop_req, stop_evt, clr_acc, clr_dbl;
  logic [N_EVT-1:0] set_vec;

  qdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({ph_a, ph_b}), .dout(ab_s)
  );

  qdec_timer #(.TICKS_PER_US(TICKS_PER_US)) u_timer (
    .clk(clk), .rst(rst), .run(running), .code(sample_code), .tick(tick)
  );

  qdec_core #(.ACC_W(ACC_W)) u_core (
    .clk(clk), .rst(rst), .restart(start_go), .tick(tick), .ab(ab_s),
    .clr_acc(clr_acc), .clr_dbl(clr_dbl), .rpt_code(report_code),
    .acc_snap(acc_snap), .dbl_snap(dbl_snap), .last_sample(last_sample),
    .sample_p(sample_p), .report_p(report_p), .ovf_p(ovf_p), .dblrdy_p(dblrdy_p)
  );

  always_comb begin
    start_go = task_start && enable && !running;
    stop_req = task_stop
             || (shortcut_en[1] && sample_p)
             || (shortcut_en[3] && report_p)
             || (shortcut_en[5] && dblrdy_p);
    stop_evt = stop_req && running && enable;
    clr_acc  = task_snap_all || task_snap_acc
             || ((shortcut_en[0] || shortcut_en[2]) && report_p)
             || (shortcut_en[6] && sample_p);
    clr_dbl  = task_snap_all || task_snap_dbl
             || (shortcut_en[0] && report_p)
             || (shortcut_en[4] && dblrdy_p)
             || (shortcut_en[6] && sample_p);
    set_vec = '0;
    set_vec[EV_SAMPLE] = sample_p;
    set_vec[EV_REPORT] = report_p;
    set_vec[EV_OVF]    = ovf_p;
    set_vec[EV_DBL]    = dblrdy_p;
    set_vec[EV_STOP]   = stop_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      evt_flags <= '0;
      irq_en    <= '0;
      irq       <= 1'b0;
    end else begin
      if (!enable || stop_req) running <= 1'b0;
      else if (start_go)       running <= 1'b1;
      evt_flags <= (evt_flags & ~evt_clr) | set_vec;
      irq_en    <= (irq_en & ~irq_en_clr) | irq_en_set;
      irq       <= |(evt_flags & irq_en);
    end
  end

  p_sample_when_running_r2: assert property (@(posedge clk) disable iff (rst)
    sample_p |-> $past(running));
  p_stop_event_r10: assert property (@(posedge clk) disable iff (rst)
    (running && enable && task_stop) |=> (evt_flags[EV_STOP] && !running));
  p_disable_halts_r10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !running);
  p_flags_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((($past(evt_flags) & ~$past(evt_clr))) & ~evt_flags) == '0));
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(irq_en) != '0));
endmodule

// File: tb/test_quad_motion_decoder.sv
module test_quad_motion_decoder;
  localparam int TPU = 1;
  localparam int AW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ph_a = 1'b0, ph_b = 1'b0, enable = 1'b0;
  logic [3:0] sample_code = '0, report_code = '0;
  logic [6:0] shortcut_en = '0;
  logic task_start = 0, task_stop = 0, task_snap_all = 0, task_snap_acc = 0, task_snap_dbl = 0;
  logic [4:0] evt_clr = '0, irq_en_set = '0, irq_en_clr = '0;
  logic [4:0] evt_flags, irq_en;
  logic irq, running;
  logic [1:0] last_sample;
  logic [AW-1:0] acc_snap;
  logic [3:0] dbl_snap;

  int total = 0, bad = 0;
  bit done = 0;
  int ph = 0;

  always #5 clk = ~clk;

  quad_motion_decoder #(.TICKS_PER_US(TPU), .ACC_W(AW)) i_quad_motion_decoder (
    .clk(clk), .rst(rst), .ph_a(ph_a), .ph_b(ph_b), .enable(enable),
    .sample_code(sample_code), .report_code(report_code), .shortcut_en(shortcut_en),
    .task_start(task_start), .task_stop(task_stop), .task_snap_all(task_snap_all),
    .task_snap_acc(task_snap_acc), .task_snap_dbl(task_snap_dbl), .evt_clr(evt_clr),
    .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr), .evt_flags(evt_flags),
    .irq_en(irq_en), .irq(irq), .running(running), .last_sample(last_sample),
    .acc_snap(acc_snap), .dbl_snap(dbl_snap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    task_start = 0; task_stop = 0; task_snap_all = 0; task_snap_acc = 0; task_snap_dbl = 0;
    evt_clr = '0; irq_en_set = '0; irq_en_clr = '0;
  endtask

  task automatic wait_sample(output int n);
    n = 0;
    for (int i = 0; i < 200000; i++) begin
      step();
      n++;
      if (evt_flags[0]) begin
        evt_clr[0] = 1'b1;
        break;
      end
    end
  endtask

  function automatic logic [1:0] gray_of(input int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic int pos_of(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

  task automatic set_ab(input logic [1:0] ab);
    ph_a = ab[1]; ph_b = ab[0];
  endtask

  task automatic move(input int d);
    int n;
    ph = (ph + d) & 3;
    set_ab(gray_of(ph));
    wait_sample(n);
  endtask

  task automatic snap(input int kind);
    step();
    if (kind == 0) task_snap_all = 1;
    else if (kind == 1) task_snap_acc = 1;
    else task_snap_dbl = 1;
    step();
  endtask

  task automatic clear_flags();
    step(); evt_clr = 5'h1f; step();
  endtask

  task automatic restart(input logic [3:0] rcode);
    int n;
    step(); task_stop = 1; step();
    report_code = rcode;
    clear_flags();
    task_start = 1; step();
  endtask

  task automatic report_len_chk(input logic [3:0] rcode, input int expn);
    int n, k;
    restart(rcode);
    k = 0;
    for (int i = 0; i < 400; i++) begin
      wait_sample(n);
      k++;
      if (evt_flags[1]) break;
    end
    chk(k == expn, "R7 report length", k, expn);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, sa;
    logic [1:0] a0, a1;
    int d, es, ei;
    repeat (5) step();
    rst = 0;
    step();
    // R1 reset state
    chk(evt_flags == 0, "R1 flags", evt_flags, 0);
    chk(irq_en == 0 && irq == 0, "R1 irq", irq, 0);
    chk(running == 0, "R1 running", running, 0);
    chk(acc_snap == 0 && dbl_snap == 0 && last_sample == 0, "R1 snapshots", acc_snap, 0);

    // R10 start ignored while disabled
    task_start = 1; step(); step();
    chk(running == 0, "R10 start while disabled", running, 0);

    enable = 1; report_code = 4'd8;
    task_start = 1; step();
    chk(running == 1, "R10 start", running, 1);

    // R2 sample intervals
    wait_sample(n);
    wait_sample(n);
    chk(n == 128, "R2 period code0", n, 128);
    sample_code = 4'd2; wait_sample(n);
    chk(n == 512, "R2 period code2", n, 512);
    sample_code = 4'd3; wait_sample(n);
    chk(n == 1024, "R2 period code3", n, 1024);
    sample_code = 4'd0; wait_sample(n);
    chk(n == 128, "R2 period back to code0", n, 128);

    // R3 sweep of every old/new state pair
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q++) begin
        a0 = p[1:0]; a1 = q[1:0];
        set_ab(a0);
        wait_sample(n); wait_sample(n);
        snap(0);
        set_ab(a1);
        wait_sample(n);
        d = (pos_of(a1) - pos_of(a0)) & 3;
        es = (d == 1) ? 1 : (d == 3) ? -1 : 0;
        ei = (d == 2) ? 1 : 0;
        sa = $signed(last_sample);
        chk(sa == es, "R3 last_sample", sa, es);
        snap(0);
        sa = $signed(acc_snap);
        chk(sa == es, "R3 step into accumulator", sa, es);
        chk(int'(dbl_snap) == ei, "R5 invalid flag per pair", dbl_snap, ei);
      end
    end
    ph = pos_of({ph_a, ph_b});

    // R4 running sum without clamping
    wait_sample(n); snap(0);
    for (int i = 0; i < 5; i++) move(1);
    for (int i = 0; i < 12; i++) move(-1);
    snap(0);
    sa = $signed(acc_snap);
    chk(sa == -7, "R4 signed sum", sa, -7);
    chk(dbl_snap == 0, "R5 no invalid on clean run", dbl_snap, 0);

    // R4 clamping at both limits
    clear_flags();
    for (int i = 0; i < 10; i++) move(1);
    chk(evt_flags[2] == 1, "R4 overflow high", evt_flags[2], 1);
    snap(0);
    sa = $signed(acc_snap);
    chk(sa == 7, "R4 clamp max", sa, 7);
    clear_flags();
    for (int i = 0; i < 12; i++) move(-1);
    chk(evt_flags[2] == 1, "R4 overflow low", evt_flags[2], 1);
    snap(0);
    sa = $signed(acc_snap);
    chk(sa == -8, "R4 clamp min", sa, -8);

    // R5 invalid count clamps at 15
    for (int i = 0; i < 17; i++) move(2);
    snap(2);
    chk(dbl_snap == 15, "R5 clamp at 15", dbl_snap, 15);
    snap(1);
    chk(acc_snap == 0, "R6 acc untouched by invalid", acc_snap, 0);

    // R6 selective snapshots
    move(2); move(2); move(1);
    snap(1);
    chk(acc_snap == 1, "R6 acc only", acc_snap, 1);
    snap(2);
    chk(dbl_snap == 2, "R6 dbl kept by acc snapshot", dbl_snap, 2);
    snap(1);
    chk(acc_snap == 0, "R6 acc cleared", acc_snap, 0);
    snap(2);
    chk(dbl_snap == 0, "R6 dbl cleared", dbl_snap, 0);

    // R7 report lengths
    report_len_chk(4'd0, 10);
    report_len_chk(4'd1, 40);
    report_len_chk(4'd2, 80);
    report_len_chk(4'd9, 10);
    report_len_chk(4'd8, 1);

    // R8 sticky flag and its clear
    repeat (3) step();
    chk(evt_flags[1] == 1, "R8 report flag sticky", evt_flags[1], 1);
    evt_clr[1] = 1; step();
    chk(evt_flags[1] == 0, "R8 flag cleared", evt_flags[1], 0);

    // R7 invalid-ready at report end
    snap(0); clear_flags();
    move(2);
    chk(evt_flags[3] == 1, "R7 invalid ready", evt_flags[3], 1);
    snap(2); clear_flags();
    move(1);
    chk(evt_flags[3] == 0, "R7 no invalid ready", evt_flags[3], 0);

    // R9 interrupt
    clear_flags();
    irq_en_set = 5'b00001; step();
    chk(irq_en == 5'b00001, "R9 enable set", irq_en, 1);
    wait_sample(n);
    step();
    chk(irq == 1, "R9 irq on enabled flag", irq, 1);
    step();
    chk(irq == 0, "R9 irq drops after clear", irq, 0);
    irq_en_clr = 5'b00001; step();
    wait_sample(n); step();
    chk(irq == 0 && irq_en == 0, "R9 disabled flag no irq", irq, 0);

    // R11 shortcuts
    snap(0);
    shortcut_en = 7'b1000000;
    move(1);
    chk(acc_snap == 1, "R11 sample->snap first", acc_snap, 1);
    move(1);
    chk(acc_snap == 1, "R11 sample->snap clears", acc_snap, 1);
    shortcut_en = 7'b0000001;
    move(1);
    chk(acc_snap == 1, "R11 report->snap", acc_snap, 1);
    shortcut_en = 7'b0010000;
    snap(0);
    move(2);
    chk(dbl_snap == 1, "R11 invalid->snap dbl", dbl_snap, 1);
    clear_flags();
    shortcut_en = 7'b0000010;
    wait_sample(n);
    chk(running == 0 && evt_flags[4] == 1, "R11 sample->stop", running, 0);
    shortcut_en = 7'b0;

    // R10 stop task and disable
    clear_flags();
    task_start = 1; step();
    task_stop = 1; step();
    chk(running == 0 && evt_flags[4] == 1, "R10 stop task", evt_flags[4], 1);
    clear_flags();
    repeat (300) step();
    chk(evt_flags[0] == 0, "R2 no sample while idle", evt_flags[0], 0);
    task_start = 1; step();
    enable = 0; step(); step();
    chk(running == 0, "R10 disable halts", running, 0);
    chk(evt_flags[4] == 0, "R10 disable no stop event", evt_flags[4], 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule